// File: doc/BRIEF.md
# Mode-Coded 20-bit SPI Flash Master

This block drives a serial flash device from a small byte-wide register window. Software places an opcode, two low address bytes and up to four payload bytes in the window. It then writes a mode byte that starts the transfer. The upper nibble of the mode byte picks one of eleven fixed command shapes. The lower nibble supplies address bits [19:16], so the flash address space ends at 1 MiB.

While a transfer runs, the block holds the chip select low. It shifts out the opcode, the optional three-byte address, any payload and any filler bytes. It shifts in the reply and stores the bytes of the read phase back into the payload registers, in the order they arrived. The register window has no back-pressure. A write that arrives while `busy` is high is dropped, so software polls `busy` before it touches the window again.

Register offsets on `reg_addr`: 0 opcode, 1 mode (trigger), 2 middle address byte, 3 low address byte, 4 to 7 payload and reply bytes.

Top module: `spim20_master`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sck` is 0, `busy` is 0, and every register offset from 0 to 7 reads as 0x00.
- R2: While idle, a write to offset 0, 2, 3, 4, 5, 6 or 7 stores the byte, and a read of the same offset returns it.
- R3: Writing offset 1 while idle with an upper nibble from 0x1 to 0xB raises `busy` and drives `spi_cs_n` low on the next clock. Both hold until the last byte is complete, and then they return together.
- R4: Writing offset 1 with an upper nibble of 0x0 or 0xC to 0xF starts nothing. `busy` stays 0, `spi_cs_n` stays 1 and no clock pulse appears.
- R5: The MOSI byte stream is MSB first. It is the opcode, then for shapes 0x4 to 0xB the three address bytes {4'b0000, mode[3:0]}, offset 2 and offset 3, then the payload taken from offset 4 upward: one byte for shapes 0x2 and 0x5, four bytes for shape 0x6. Shape 0x1 sends only the opcode.
- R6: Shape 0x7 places one filler byte of 0x00 after the address and ahead of four read bytes. The byte received during the filler is not stored.
- R7: Read-phase bytes are clocked out as 0x00. The bytes received (2 for shape 0x3, and 1, 2, 3 or 4 for shapes 0x8, 0x9, 0xA and 0xB) land in offsets 4, 5 and so on, in receive order. Payload offsets past the read count keep their values.
- R8: The SPI link runs in mode 0. `spi_sck` is low whenever `spi_cs_n` is high, and `spi_mosi` does not change while `spi_sck` is high.
- R9: Any register write made while `busy` is 1 is ignored. This includes a second trigger write.
- R10: A transfer gives exactly eight `spi_sck` rising edges per byte of its shape. Shape 0x7 gives 72.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the register window |
| reg_addr | input | 3 | Register offset for writes and reads |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data at `reg_addr` (combinational) |
| busy | output | 1 | High while a transfer runs |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
Every one of the eleven shape codes is launched with its own opcode, address and payload values. A serial target model returns a reply byte that encodes both the transfer number and the byte position. This lets a misplaced, skipped or stale read byte show up as a distinct wrong value. It also separates shape 0x7, with its discarded filler, from shape 0xB. The scoreboard compares every MOSI byte against the sequence the shape predicts and counts clock edges, which exposes wrong address nibbles, payload order and byte counts. Illegal codes at both ends of the range, and writes made during a transfer, are checked to leave the bus quiet and the registers unchanged.

// File: rtl/spim20_pkg.sv
package spim20_pkg;
  localparam int DATA_REGS = 4;
  localparam int IDX_W     = 4;

  typedef struct packed {
    logic       ok;
    logic       addr;
    logic       dummy;
    logic [2:0] n_wr;
    logic [2:0] n_rd;
  } shape_t;

  function automatic shape_t decode_shape(input logic [3:0] code);
    shape_t s;
    s = '0;
    case (code)
      4'h1: s.ok = 1'b1;
      4'h2: begin s.ok = 1'b1; s.n_wr = 3'd1; end
      4'h3: begin s.ok = 1'b1; s.n_rd = 3'd2; end
      4'h4: begin s.ok = 1'b1; s.addr = 1'b1; end
      4'h5: begin s.ok = 1'b1; s.addr = 1'b1; s.n_wr = 3'd1; end
      4'h6: begin s.ok = 1'b1; s.addr = 1'b1; s.n_wr = 3'd4; end
      4'h7: begin s.ok = 1'b1; s.addr = 1'b1; s.dummy = 1'b1; s.n_rd = 3'd4; end
      4'h8, 4'h9, 4'hA, 4'hB: begin
        s.ok   = 1'b1;
        s.addr = 1'b1;
        s.n_rd = 3'(code - 4'h7);
      end
      default: s = '0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/spim20_shift.sv
module spim20_shift #(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       done,
  output logic [7:0] rx_byte
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

  logic             active;
  logic [2:0]       bit_cnt;
  logic [DIV_W-1:0] div_cnt;
  logic [7:0]       tx_sh;
  logic [7:0]       rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      bit_cnt <= '0;
      div_cnt <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      sck     <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !active) begin
        active  <= 1'b1;
        tx_sh   <= tx_byte;
        bit_cnt <= '0;
        div_cnt <= '0;
        sck     <= 1'b0;
      end else if (active) begin
        if (div_cnt == DIV_LAST) begin
          div_cnt <= '0;
          if (!sck) begin
            sck   <= 1'b1;
            rx_sh <= {rx_sh[6:0], miso};
          end else begin
            sck <= 1'b0;
            if (bit_cnt == 3'd7) begin
              active <= 1'b0;
              done   <= 1'b1;
            end else begin
              bit_cnt <= bit_cnt + 3'd1;
              tx_sh   <= {tx_sh[6:0], 1'b0};
            end
          end
        end else begin
          div_cnt <= div_cnt + 1'b1;
        end
      end
    end
  end

  assign mosi    = tx_sh[7];
  assign rx_byte = rx_sh;
endmodule

// File: rtl/spim20_seq.sv
module spim20_seq
  import spim20_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   launch,
  input  logic [7:0]             launch_mode,
  input  logic [7:0]             opcode,
  input  logic [7:0]             addr_mid,
  input  logic [7:0]             addr_lo,
  input  logic [8*DATA_REGS-1:0] wr_bytes,
  input  logic                   xfer_done,
  input  logic [7:0]             rx_byte,
  output logic                   busy,
  output logic                   cs_n,
  output logic                   xfer_start,
  output logic [7:0]             tx_byte,
  output logic                   rx_we,
  output logic [1:0]             rx_idx,
  output logic [7:0]             rx_data
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} st_t;

  st_t              state;
  shape_t           sh;
  logic [3:0]       hi_nib;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] wr_base, rd_start, total, wr_off;

  always_comb begin
    wr_base  = sh.addr ? IDX_W'(4) : IDX_W'(1);
    rd_start = wr_base + IDX_W'(sh.n_wr) + IDX_W'(sh.dummy);
    total    = rd_start + IDX_W'(sh.n_rd);
    wr_off   = idx - wr_base;
  end

  always_comb begin
    tx_byte = 8'h00;
    if (idx == '0) begin
      tx_byte = opcode;
    end else if (sh.addr && idx == IDX_W'(1)) begin
      tx_byte = {4'b0000, hi_nib};
    end else if (sh.addr && idx == IDX_W'(2)) begin
      tx_byte = addr_mid;
    end else if (sh.addr && idx == IDX_W'(3)) begin
      tx_byte = addr_lo;
    end else if (idx >= wr_base && wr_off < IDX_W'(sh.n_wr)) begin
      tx_byte = wr_bytes[8*wr_off[1:0] +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      sh     <= '0;
      hi_nib <= '0;
      idx    <= '0;
      cs_n   <= 1'b1;
    end else begin
      case (state)
        S_IDLE: if (launch) begin
          sh     <= decode_shape(launch_mode[7:4]);
          hi_nib <= launch_mode[3:0];
          idx    <= '0;
          cs_n   <= 1'b0;
          state  <= S_ISSUE;
        end
        S_ISSUE: state <= S_WAIT;
        S_WAIT: if (xfer_done) begin
          if (idx == total - IDX_W'(1)) begin
            cs_n  <= 1'b1;
            state <= S_IDLE;
          end else begin
            idx   <= idx + IDX_W'(1);
            state <= S_ISSUE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy       = (state != S_IDLE);
  assign xfer_start = (state == S_ISSUE);
  assign rx_we      = (state == S_WAIT) && xfer_done && (idx >= rd_start);
  assign rx_idx     = 2'(idx - rd_start);
  assign rx_data    = rx_byte;
endmodule

// File: rtl/spim20_regs.sv
module spim20_regs
  import spim20_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr,
  input  logic [2:0]             addr,
  input  logic [7:0]             wdata,
  output logic [7:0]             rdata,
  input  logic                   busy,
  input  logic                   rx_we,
  input  logic [1:0]             rx_idx,
  input  logic [7:0]             rx_data,
  output logic [7:0]             opcode,
  output logic [7:0]             addr_mid,
  output logic [7:0]             addr_lo,
  output logic [8*DATA_REGS-1:0] wr_bytes,
  output logic                   launch
);
  logic [7:0] mode_q;
  logic       wr_ok;
  shape_t     req_shape;

  assign wr_ok     = wr && !busy;
  assign req_shape = decode_shape(wdata[7:4]);
  assign launch    = wr_ok && (addr == 3'd1) && req_shape.ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opcode   <= '0;
      addr_mid <= '0;
      addr_lo  <= '0;
      mode_q   <= '0;
    end else if (wr_ok) begin
      case (addr)
        3'd0: opcode   <= wdata;
        3'd1: if (req_shape.ok) mode_q <= wdata;
        3'd2: addr_mid <= wdata;
        3'd3: addr_lo  <= wdata;
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < DATA_REGS; g++) begin : g_data
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wr_bytes[8*g +: 8] <= '0;
      end else if (rx_we && rx_idx == 2'(g)) begin
        wr_bytes[8*g +: 8] <= rx_data;
      end else if (wr_ok && addr == 3'(4 + g)) begin
        wr_bytes[8*g +: 8] <= wdata;
      end
    end
  end

  always_comb begin
    case (addr)
      3'd0:    rdata = opcode;
      3'd1:    rdata = mode_q;
      3'd2:    rdata = addr_mid;
      3'd3:    rdata = addr_lo;
      default: rdata = wr_bytes[8*(addr[1:0]) +: 8];
    endcase
  end
endmodule

// File: rtl/spim20_master.sv
module spim20_master
  import spim20_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       busy,
  output logic       spi_sck,
  output logic       spi_cs_n,
  output logic       spi_mosi,
  input  logic       spi_miso
);
  logic [7:0]             opcode, addr_mid, addr_lo, tx_byte, rx_byte, rx_data;
  logic [8*DATA_REGS-1:0] wr_bytes;
  logic                   launch, xfer_start, xfer_done, rx_we;
  logic [1:0]             rx_idx;

  spim20_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .busy(busy), .rx_we(rx_we), .rx_idx(rx_idx),
    .rx_data(rx_data), .opcode(opcode), .addr_mid(addr_mid), .addr_lo(addr_lo),
    .wr_bytes(wr_bytes), .launch(launch)
  );

  spim20_seq u_seq (
    .clk(clk), .rst_n(rst_n), .launch(launch), .launch_mode(reg_wdata),
    .opcode(opcode), .addr_mid(addr_mid), .addr_lo(addr_lo), .wr_bytes(wr_bytes),
    .xfer_done(xfer_done), .rx_byte(rx_byte), .busy(busy), .cs_n(spi_cs_n),
    .xfer_start(xfer_start), .tx_byte(tx_byte), .rx_we(rx_we), .rx_idx(rx_idx),
    .rx_data(rx_data)
  );

  spim20_shift #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(xfer_start), .tx_byte(tx_byte),
    .miso(spi_miso), .sck(spi_sck), .mosi(spi_mosi), .done(xfer_done),
    .rx_byte(rx_byte)
  );
endmodule

// File: rtl/spim20_chk.sv
module spim20_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [2:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic       busy,
  input logic       spi_sck,
  input logic       spi_cs_n,
  input logic       spi_mosi,
  input logic [7:0] opcode
);
  // R8
  idle_sck_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);

  // R8
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

  // R3
  launch_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_wr && reg_addr == 3'd1));

  // R3
  cs_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy != spi_cs_n);

  // R4
  bad_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && reg_wr && reg_addr == 3'd1 &&
     (reg_wdata[7:4] == 4'h0 || reg_wdata[7:4] > 4'hB)) |=> !busy);

  // R9
  busy_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_addr == 3'd0) |=> $stable(opcode));
endmodule

bind spim20_master spim20_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .busy(busy), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
  .spi_mosi(spi_mosi), .opcode(opcode)
);

// File: tb/spim20_master_test.sv
`timescale 1ns/1ps
module spim20_master_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       busy, spi_sck, spi_cs_n, spi_mosi, spi_miso;

  int tests = 0;
  int fails = 0;
  int txn_id = 0;
  int sck_rises = 0;
  logic [7:0] exp_q[$];

  always #2 clk = ~clk;

  spim20_master uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  function automatic logic [7:0] resp_of(input int t, input int k);
    return {t[3:0], k[3:0]} ^ 8'h3C;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // serial target model and monitor
  logic [3:0] s_bit = '0;
  int         s_byte = 0;
  logic [7:0] s_shin = '0;
  logic [7:0] s_cur;
  assign s_cur    = resp_of(txn_id, s_byte);
  assign spi_miso = spi_cs_n ? 1'b0 : s_cur[3'(7 - s_bit)];

  always @(negedge spi_sck or posedge spi_cs_n) begin
    if (spi_cs_n) begin
      s_bit  = '0;
      s_byte = 0;
    end else if (s_bit == 4'd7) begin
      s_bit = '0;
      s_byte++;
    end else begin
      s_bit++;
    end
  end

  always @(posedge spi_sck) begin
    logic [7:0] e;
    sck_rises++;
    s_shin = {s_shin[6:0], spi_mosi};
    if (s_bit == 4'd7) begin
      if (exp_q.size() == 0) begin
        tests++; fails++;
        $display("FAIL R5: actual %02h expected none (extra byte)", s_shin);
      end else begin
        e = exp_q.pop_front();
        check("R5 mosi byte", s_shin, e);
      end
    end
  end

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
  endtask

  // driver: loads the window, predicts bytes and reply, launches
  task automatic run_txn(input logic [7:0] mode, input logic [7:0] op,
                         input logic [7:0] a1, input logic [7:0] a2,
                         input logic [31:0] wd, input bit poke);
    int n_wr = 0, n_rd = 0, nbytes, rd_start;
    bit has_addr = 0, dummy = 0;
    logic [7:0] v;
    case (mode[7:4])
      4'h2: n_wr = 1;
      4'h3: n_rd = 2;
      4'h4: has_addr = 1;
      4'h5: begin has_addr = 1; n_wr = 1; end
      4'h6: begin has_addr = 1; n_wr = 4; end
      4'h7: begin has_addr = 1; dummy = 1; n_rd = 4; end
      4'h8, 4'h9, 4'hA, 4'hB: begin has_addr = 1; n_rd = int'(mode[7:4]) - 7; end
      default: ;
    endcase
    bus_write(3'd0, op); bus_write(3'd2, a1); bus_write(3'd3, a2);
    for (int i = 0; i < 4; i++) bus_write(3'(4 + i), wd[8*i +: 8]);
    exp_q.push_back(op);
    if (has_addr) begin
      exp_q.push_back({4'b0000, mode[3:0]});
      exp_q.push_back(a1);
      exp_q.push_back(a2);
    end
    for (int i = 0; i < n_wr; i++) exp_q.push_back(wd[8*i +: 8]);
    if (dummy) exp_q.push_back(8'h00);   // R6 filler
    for (int i = 0; i < n_rd; i++) exp_q.push_back(8'h00);
    rd_start = 1 + (has_addr ? 3 : 0) + n_wr + (dummy ? 1 : 0);
    nbytes   = rd_start + n_rd;
    txn_id++;
    sck_rises = 0;
    bus_write(3'd1, mode);
    check("R3 busy after trigger", {7'd0, busy}, 8'd1);
    check("R3 cs low after trigger", {7'd0, spi_cs_n}, 8'd0);
    if (poke) begin   // R9
      bus_write(3'd0, 8'h77);
      bus_write(3'd1, 8'h10);
      bus_write(3'd2, 8'h33);
    end
    wait_idle();
    @(negedge clk);
    check("R3 cs high after end", {7'd0, spi_cs_n}, 8'd1);
    check("R10 sck pulse count", 8'(sck_rises), 8'(8 * nbytes));
    check("R5 all bytes seen", 8'(exp_q.size()), 8'd0);
    exp_q.delete();
    for (int j = 0; j < 4; j++) begin
      bus_read(3'(4 + j), v);
      if (j < n_rd) check(dummy ? "R6 R7 reply byte" : "R7 reply byte", v, resp_of(txn_id, rd_start + j));
      else          check("R7 untouched payload", v, wd[8*j +: 8]);
    end
    if (poke) begin
      bus_read(3'd0, v); check("R9 opcode kept", v, op);
      bus_read(3'd2, v); check("R9 addr kept", v, a1);
    end
  endtask

  task automatic bad_mode(input logic [7:0] mode);
    sck_rises = 0;
    bus_write(3'd1, mode);
    repeat (20) @(negedge clk);
    check("R4 busy stays low", {7'd0, busy}, 8'd0);
    check("R4 cs stays high", {7'd0, spi_cs_n}, 8'd1);
    check("R4 no sck pulse", 8'(sck_rises), 8'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1 cs_n", {7'd0, spi_cs_n}, 8'd1);
    check("R1 sck", {7'd0, spi_sck}, 8'd0);
    check("R1 busy", {7'd0, busy}, 8'd0);
    for (int a = 0; a < 8; a++) begin
      bus_read(3'(a), v); check("R1 reg zero", v, 8'h00);
    end
    // R2
    bus_write(3'd0, 8'h9F); bus_read(3'd0, v); check("R2 opcode", v, 8'h9F);
    bus_write(3'd3, 8'hC4); bus_read(3'd3, v); check("R2 addr lo", v, 8'hC4);
    bus_write(3'd6, 8'h5E); bus_read(3'd6, v); check("R2 payload", v, 8'h5E);
    // R4 boundaries
    bad_mode(8'h05);
    bad_mode(8'hC3);
    bad_mode(8'hF0);
    // R5 R6 R7 R10 every shape
    run_txn(8'h10, 8'h06, 8'h11, 8'h22, 32'hD4C3B2A1, 0);
    run_txn(8'h20, 8'h01, 8'h11, 8'h22, 32'h44332281, 0);
    run_txn(8'h30, 8'h9F, 8'h11, 8'h22, 32'hEEDDCCBB, 0);
    run_txn(8'h4A, 8'h20, 8'h5B, 8'hC6, 32'h01020304, 0);
    run_txn(8'h5F, 8'h02, 8'hA5, 8'h0F, 32'h000000E7, 0);
    run_txn(8'h63, 8'h02, 8'h80, 8'h01, 32'hCAFEF00D, 0);
    run_txn(8'h71, 8'h0B, 8'h23, 8'h45, 32'h99887766, 0);
    run_txn(8'h82, 8'h03, 8'h00, 8'hFF, 32'h55443322, 0);
    run_txn(8'h9C, 8'h03, 8'h7E, 8'h81, 32'h12345678, 0);
    run_txn(8'hA8, 8'h03, 8'h10, 8'h20, 32'hA0B0C0D0, 0);
    run_txn(8'hB7, 8'h03, 8'hFF, 8'hFE, 32'h0BADBEEF, 0);
    // R9 writes during a transfer
    run_txn(8'hB5, 8'h0B, 8'h42, 8'h24, 32'h11111111, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule